// File: doc/BRIEF.md
# Prefetch Stream Buffer

This block is a small fully associative store for cache blocks that a prefetch engine has brought back from the next memory level. These blocks are kept here rather than in the L1 data cache, so speculative data cannot push useful lines out of the cache. Returned prefetch blocks arrive on a fill port as a block address plus the block data. Every demand lookup from the cache miss path compares its block address against all entries at once.

On a lookup hit the block is returned, the demand request toward the next level is cancelled, and the same block is presented on a transfer port for the data cache to install. The entry is then released. When a fill finds no free entry, the least recently filled valid block is dropped. Issuing the prefetch requests themselves is handled elsewhere.

Top module: `psb_stream_buffer`

## Requirements
- R1: After reset the buffer is empty and every output is 0; a lookup made before any fill misses.
- R2: A filled block is found by a later lookup of the same block address, which returns the data of the most recent fill of that address; a fill of an address already held replaces that entry's data and never creates a second copy.
- R3: Each lookup presented in cycle N is answered in cycle N+1 with `resp_valid` = 1; `resp_valid` is 0 in a cycle that follows a cycle with no lookup.
- R4: On a hit, `resp_hit`, `dmd_cancel` and `xfer_valid` are all 1 in the response cycle, `xfer_addr` carries the looked-up address and `xfer_data` equals `resp_data`; on a miss or with no lookup these outputs are 0 and the data and address outputs read 0.
- R5: A hit releases its entry, so a second lookup of that address with no fill in between misses.
- R6: A fill of a new address while all entries are valid and no entry is released that cycle discards the entry whose last fill or overwrite is oldest; every other entry stays.
- R7: Overwriting an existing address counts as its most recent use for replacement.
- R8: When a lookup and a fill carry the same address in one cycle, the lookup hits and returns the fill data, and the block is not kept in the buffer afterwards.
- R9: When a lookup hit releases an entry in the same cycle as a fill of a new address into a full buffer, the fill uses the released space and no other entry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | A returned prefetch block is present |
| fill_addr | input | ADDR_W | Block address of the returned block |
| fill_data | input | DATA_W | Data of the returned block |
| lk_valid | input | 1 | A demand lookup is present |
| lk_addr | input | ADDR_W | Block address of the demand lookup |
| resp_valid | output | 1 | Answer to the lookup of the previous cycle |
| resp_hit | output | 1 | The looked-up block was present |
| resp_data | output | DATA_W | Block data on a hit, 0 otherwise |
| dmd_cancel | output | 1 | Cancel the pending demand request to the next level |
| xfer_valid | output | 1 | Block offered to the data cache for install |
| xfer_addr | output | ADDR_W | Address of the offered block |
| xfer_data | output | DATA_W | Data of the offered block |

## Verification
Every result of this block is due exactly one cycle after the lookup that caused it, while the effect of a fill or a release shows only in later lookups. The bench drives one cycle of stimulus on the falling edge, lets one rising edge pass, and compares all outputs on the next falling edge against a queue model kept in recency order, so each comparison lands in the response cycle. State effects such as eviction, release and overwrite are observed through follow-up lookups issued in later cycles.

// File: rtl/psb_pkg.sv
package psb_pkg;

  // Index of the lowest set bit of a vector of up to 64 bits (0 when empty).
  function automatic int lowest_set(input logic [63:0] v);
    int r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/psb_tag_cam.sv
module psb_tag_cam #(
  parameter int N      = 8,
  parameter int ADDR_W = 27,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cmp_a,
  input  logic [ADDR_W-1:0] cmp_b,
  output logic [N-1:0]      hit_a,
  output logic [N-1:0]      hit_b,
  output logic [N-1:0]      valid_o,
  input  logic              set_en,
  input  logic [IW-1:0]     set_idx,
  input  logic [ADDR_W-1:0] set_tag,
  input  logic [N-1:0]      clr_vec
);

  logic [ADDR_W-1:0] tag_q [N];
  logic [N-1:0]      vld_q;
  logic [N-1:0]      set_vec;

  assign set_vec = set_en ? (N'(1) << set_idx) : '0;
  assign valid_o = vld_q;

  // Parallel compare of both addresses against every entry.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_a[g] = vld_q[g] && (tag_q[g] == cmp_a);
    assign hit_b[g] = vld_q[g] && (tag_q[g] == cmp_b);

    always_ff @(posedge clk) begin
      if (set_vec[g]) tag_q[g] <= set_tag;
    end
  end

  // A released slot may be refilled in the same cycle: set wins over clear.
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= (vld_q & ~clr_vec) | set_vec;
  end

  // R2: no address is ever held twice.
  a_r2_unique_a: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_a));
  a_r2_unique_b: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_b));

endmodule

// File: rtl/psb_lru_age.sv
module psb_lru_age #(
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] lru_idx
);

  // Ages form a permutation of 0..N-1; 0 is most recent, N-1 oldest.
  logic [IW-1:0] age_q [N];
  logic [IW-1:0] ref_age;
  logic [N-1:0]  oldest;

  assign ref_age = age_q[touch_idx];

  for (genvar g = 0; g < N; g++) begin : g_age
    assign oldest[g] = (age_q[g] == IW'(N - 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        age_q[g] <= IW'(g);
      end else if (touch_en) begin
        if (touch_idx == IW'(g))    age_q[g] <= '0;
        else if (age_q[g] < ref_age) age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  assign lru_idx = IW'(psb_pkg::lowest_set(64'(oldest)));

  // R6: exactly one entry is the replacement candidate.
  a_r6_single_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest) == 1);

endmodule

// File: rtl/psb_data_store.sv
module psb_data_store #(
  parameter int N      = 8,
  parameter int DATA_W = 64,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IW-1:0]     ridx,
  output logic [DATA_W-1:0] rq
);

  logic [DATA_W-1:0] mem [N];

  // One write port and one registered read port, read-first on collision.
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rq <= mem[ridx];
  end

endmodule

// File: rtl/psb_stream_buffer.sv
module psb_stream_buffer #(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 27,
  parameter int DATA_W    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              dmd_cancel,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [DATA_W-1:0] xfer_data
);

  localparam int IW = $clog2(N_ENTRIES);

  logic [N_ENTRIES-1:0] lk_match, fl_match, valid, clr_vec, free_vec;
  logic                 same_blk, lk_found, any_hit, fill_go;
  logic [IW-1:0]        lk_idx, slot_idx, lru_idx;

  logic                 rv_q, hit_q, byp_q;
  logic [DATA_W-1:0]    byp_data_q, rd_q;
  logic [ADDR_W-1:0]    xaddr_q;

  psb_tag_cam #(.N(N_ENTRIES), .ADDR_W(ADDR_W)) u_cam (
    .clk(clk), .rst(rst),
    .cmp_a(lk_addr), .cmp_b(fill_addr),
    .hit_a(lk_match), .hit_b(fl_match), .valid_o(valid),
    .set_en(fill_go), .set_idx(slot_idx), .set_tag(fill_addr),
    .clr_vec(clr_vec)
  );

  psb_lru_age #(.N(N_ENTRIES)) u_age (
    .clk(clk), .rst(rst),
    .touch_en(fill_go), .touch_idx(slot_idx), .lru_idx(lru_idx)
  );

  psb_data_store #(.N(N_ENTRIES), .DATA_W(DATA_W)) u_mem (
    .clk(clk),
    .we(fill_go), .widx(slot_idx), .wdata(fill_data),
    .re(lk_found), .ridx(lk_idx), .rq(rd_q)
  );

  // Lookup side: a hit in the array or on the fill arriving this cycle.
  assign same_blk = lk_valid && fill_valid && (lk_addr == fill_addr);
  assign lk_found = lk_valid && (|lk_match);
  assign any_hit  = lk_found || same_blk;
  assign lk_idx   = IW'(psb_pkg::lowest_set(64'(lk_match)));
  assign clr_vec  = lk_valid ? lk_match : '0;

  // Fill side: a block handed straight to the cache is not stored.
  assign fill_go  = fill_valid && !same_blk;
  assign free_vec = ~valid | clr_vec;

  always_comb begin
    if (|fl_match)      slot_idx = IW'(psb_pkg::lowest_set(64'(fl_match)));
    else if (|free_vec) slot_idx = IW'(psb_pkg::lowest_set(64'(free_vec)));
    else                slot_idx = lru_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q       <= 1'b0;
      hit_q      <= 1'b0;
      byp_q      <= 1'b0;
      byp_data_q <= '0;
      xaddr_q    <= '0;
    end else begin
      rv_q       <= lk_valid;
      hit_q      <= any_hit;
      byp_q      <= same_blk;
      byp_data_q <= fill_data;
      xaddr_q    <= any_hit ? lk_addr : '0;
    end
  end

  assign resp_valid = rv_q;
  assign resp_hit   = hit_q;
  assign resp_data  = hit_q ? (byp_q ? byp_data_q : rd_q) : '0;
  assign dmd_cancel = hit_q;
  assign xfer_valid = hit_q;
  assign xfer_addr  = xaddr_q;
  assign xfer_data  = resp_data;

  // R3: one answer per lookup, one cycle later.
  a_r3_answer_due: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> resp_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !resp_valid);
  // R4: the offered block carries the looked-up address.
  a_r4_xfer_addr: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> (xfer_valid && xfer_addr == $past(lk_addr)));
  // R8: same-cycle fill is seen by the lookup.
  a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && fill_valid && lk_addr == fill_addr) |=>
      (resp_hit && resp_data == $past(fill_data)));

endmodule

// File: tb/psb_stream_buffer_tb.sv
`timescale 1ns/1ps
module psb_stream_buffer_tb;
  localparam int N  = 8;
  localparam int AW = 27;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst;
  always #2.5 clk = ~clk;

  logic          fill_valid, lk_valid;
  logic [AW-1:0] fill_addr, lk_addr;
  logic [DW-1:0] fill_data;
  logic          resp_valid, resp_hit, dmd_cancel, xfer_valid;
  logic [DW-1:0] resp_data, xfer_data;
  logic [AW-1:0] xfer_addr;

  psb_stream_buffer #(.N_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .dmd_cancel(dmd_cancel), .xfer_valid(xfer_valid),
    .xfer_addr(xfer_addr), .xfer_data(xfer_data)
  );

  // Reference: contents in recency order, front is least recent.
  logic [AW-1:0] m_addr[$];
  logic [DW-1:0] m_data[$];

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string req   = "R1";
  logic [31:0] seed = 32'h1234_5679;

  logic          e_rv, e_hit;
  logic [DW-1:0] e_d;
  logic [AW-1:0] e_xa;

  function automatic logic [DW-1:0] mk(input logic [AW-1:0] a, input int salt);
    return {32'(a), 32'(salt)} ^ 64'hC3A5_0000_5A3C_0000;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic field(input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, inout bit bad);
    if (act !== exp) begin
      bad = 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic fv, input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                      input logic lv, input logic [AW-1:0] la);
    int hi, fi;
    bit bad;
    fill_valid = fv; fill_addr = fa; fill_data = fd;
    lk_valid = lv;   lk_addr = la;
    hi = -1;
    for (int i = 0; i < m_addr.size(); i++) if (m_addr[i] == la) hi = i;
    e_rv = lv; e_hit = 0; e_d = '0; e_xa = '0;
    if (lv) begin
      if (fv && fa == la) begin e_hit = 1; e_d = fd; end
      else if (hi >= 0)   begin e_hit = 1; e_d = m_data[hi]; end
      if (hi >= 0) begin m_addr.delete(hi); m_data.delete(hi); end
      if (e_hit) e_xa = la;
    end
    if (fv && !(lv && fa == la)) begin
      fi = -1;
      for (int i = 0; i < m_addr.size(); i++) if (m_addr[i] == fa) fi = i;
      if (fi >= 0) begin m_addr.delete(fi); m_data.delete(fi); end
      else if (m_addr.size() == N) begin void'(m_addr.pop_front()); void'(m_data.pop_front()); end
      m_addr.push_back(fa); m_data.push_back(fd);
    end
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    bad = 0;
    field("resp_valid (R3)", DW'(resp_valid), DW'(e_rv), bad);
    field("resp_hit", DW'(resp_hit), DW'(e_hit), bad);
    field("resp_data", resp_data, e_d, bad);
    field("dmd_cancel (R4)", DW'(dmd_cancel), DW'(e_hit), bad);
    field("xfer_valid (R4)", DW'(xfer_valid), DW'(e_hit), bad);
    field("xfer_addr (R4)", DW'(xfer_addr), DW'(e_xa), bad);
    field("xfer_data (R4)", xfer_data, e_d, bad);
    if (bad) n_bad++;
  endtask

  task automatic fill(input logic [AW-1:0] a, input int salt);
    step(1'b1, a, mk(a, salt), 1'b0, '0);
  endtask
  task automatic look(input logic [AW-1:0] a);
    step(1'b0, '0, '0, 1'b1, a);
  endtask
  task automatic drain();
    while (m_addr.size() > 0) look(m_addr[0]);
  endtask

  initial begin
    fill_valid = 0; lk_valid = 0; fill_addr = '0; lk_addr = '0; fill_data = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: quiet outputs after reset, first lookup misses.
    req = "R1";
    step(1'b0, '0, '0, 1'b0, '0);
    look(27'h40);
    // R2: fill, hit, overwrite without duplicate.
    req = "R2";
    fill(27'h100, 1); fill(27'h101, 2); fill(27'h102, 3);
    look(27'h101);
    fill(27'h100, 9);
    look(27'h100);
    look(27'h100);
    // R5: hit releases the entry.
    req = "R5";
    look(27'h102);
    look(27'h102);
    drain();
    // R6: eviction of the oldest fill when full.
    req = "R6";
    for (int i = 0; i < N; i++) fill(27'h200 + AW'(i), i);
    fill(27'h2FF, 77);
    look(27'h200);
    for (int i = 1; i < N; i++) look(27'h200 + AW'(i));
    look(27'h2FF);
    // R7: overwrite refreshes recency.
    req = "R7";
    for (int i = 0; i < N; i++) fill(27'h300 + AW'(i), i);
    fill(27'h300, 50);
    fill(27'h3F0, 51);
    look(27'h301);
    look(27'h300);
    drain();
    // R8: same-cycle lookup and fill of one address.
    req = "R8";
    fill(27'h400, 1);
    step(1'b1, 27'h400, mk(27'h400, 2), 1'b1, 27'h400);
    look(27'h400);
    step(1'b1, 27'h401, mk(27'h401, 3), 1'b1, 27'h401);
    look(27'h401);
    // R9: released slot reused by a fill into a full buffer.
    req = "R9";
    for (int i = 0; i < N; i++) fill(27'h500 + AW'(i), i);
    step(1'b1, 27'h5F0, mk(27'h5F0, 4), 1'b1, 27'h503);
    for (int i = 0; i < N; i++) look(27'h500 + AW'(i));
    look(27'h5F0);
    // R2: mixed traffic over a small address set.
    req = "R2";
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = rnd();
      step(r[0], 27'h600 + AW'(r[7:4] % 12), {rnd(), rnd()},
           r[1] | ~r[0], 27'h600 + AW'(r[15:12] % 12));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule